// File: doc/BRIEF.md
# Segment Lookaside Buffer Array

This block is a small, fully associative table of segment descriptors used in front of an address translator. Every entry pairs a tag word (an effective segment number plus a valid flag) with a segment word (segment size, class flag, base page-size code and a translation payload). A dedicated lookup port compares an effective address against all entries in the same cycle and returns a hit flag, the index of the matching entry and its segment word. An entry covers either a 256 MB or a 1 TB region of the effective address space, as selected by the size field of its own segment word.

The table is maintained through a command port. A command is presented with `cmd_valid` for one cycle and its response appears on the next cycle with `rsp_valid`. The commands are indexed write with validity checks, indexed read of either word, search by address, single-entry invalidate (with a local or global flush request) and a coded bulk invalidate that can spare entry 0 or spare entries by class. A purge command clears every entry. Every bulk invalidate raises a local flush request for the translation caches downstream.

Top module: `slb_array`

## Requirements
- R1: After reset every entry is invalid: lookups miss, reads of the tag word return all zeros, and `rsp_valid`, `flush_local` and `flush_global` are low.
- R2: Opcodes are 0 write, 1 read tag, 2 read segment, 3 find, 4 invalidate-local, 5 invalidate-global, 6 bulk invalidate by code, 7 purge. For write, `cmd_a[11:0]` is the slot, `cmd_a[63:28]` the segment number, `cmd_a[27]` the valid flag, and `cmd_b` is stored whole as the segment word. Read tag returns `{segment number, valid, 27 zeros}` and read segment returns the stored segment word; a read of a slot at or above the table size reports `rsp_err` with data zero.
- R3: A write is rejected with `rsp_err` and leaves the table unchanged when the slot is at or above the table size, when any of `cmd_a[26:12]` is set, when the size code `cmd_b[63:62]` is neither 00 (256 MB) nor 01 (1 TB), when the code is 01 while `en_1t` is low, or when the page-size code `cmd_b[5:4]` is not enabled in `PSZ_MASK` (default: codes 0, 1 and 3 enabled).
- R4: An entry with size code 00 matches when it is valid and its stored segment number equals address bits 63:28.
- R5: An entry with size code 01 matches when it is valid and its stored segment number equals address bits 63:40 followed by twelve zero bits; address bits 39:28 are not compared.
- R6: When several entries match, the lowest index is reported and acted on.
- R7: Find returns the segment word of the matching entry, or all ones when nothing matches, with `rsp_err` low; when `mode64` is low, only the low 32 bits of `cmd_a` are used as the address.
- R8: Invalidate-local and invalidate-global clear the valid flag of the entry that matches `cmd_a` and, only when an entry was cleared, pulse `flush_local` or `flush_global` respectively; on a miss nothing changes and neither flush pulses.
- R9: Bulk invalidate with code (`cmd_code`) 0, 1, 2, 5 or 6 clears every entry except entry 0; codes 3 and 4 include entry 0; code 7 clears no entry.
- R10: Bulk invalidate with code 3 keeps every entry whose class flag (`cmd_b[8]` when written) is 0.
- R11: Every bulk invalidate and every purge pulses `flush_local` (never `flush_global`), even when no entry changes; purge clears all entries including entry 0.
- R12: Each accepted command yields `rsp_valid` for exactly the following cycle, with flush pulses in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Opcode (see R2) |
| cmd_a | input | 64 | Tag/slot operand or search address |
| cmd_b | input | 64 | Segment word for write |
| cmd_code | input | 3 | Bulk invalidate variant |
| mode64 | input | 1 | Find uses the full 64-bit address when high |
| en_1t | input | 1 | 1 TB segments accepted by write when high |
| lk_seg_addr | input | 36 | Address bits 63:28 for the lookup port |
| lk_hit | output | 1 | Lookup matched an entry |
| lk_idx | output | IDX_W | Index of the matching entry |
| lk_seg | output | 64 | Segment word of the matching entry |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Command rejected |
| rsp_data | output | 64 | Read or find result |
| flush_local | output | 1 | Local translation flush request |
| flush_global | output | 1 | Global translation flush request |

## Verification
The lookup port is swept with keys derived from every stored entry: the exact number, a flip of bit 0, a flip of bit 11 and a flip of bit 12, which separates a 256 MB compare from a 1 TB compare. A duplicated segment number tells the priority order apart from any other choice, and a key whose upper half differs separates find with and without 32-bit truncation. Bulk invalidate is tried with all eight codes on a freshly filled table with mixed class flags, which distinguishes the entry-0 rule, the class rule and the no-op code, while each write rejection is followed by a read-back that shows the table kept its contents.

// File: rtl/slb_pkg.sv
// Shared field positions, opcodes and size codes of the segment table.
package slb_pkg;
    localparam int WORD_W     = 64;
    localparam int SLOT_W     = 12;
    localparam int ESID_LSB   = 28;
    localparam int ESID_W     = WORD_W - ESID_LSB;
    localparam int VALID_BIT  = 27;
    localparam int RSV_MSB    = 26;
    localparam int RSV_LSB    = SLOT_W;
    localparam int TERA_LSB   = 40;
    localparam int TERA_LOW_W = TERA_LSB - ESID_LSB;
    localparam int SIZE_MSB   = 63;
    localparam int SIZE_LSB   = 62;
    localparam int SIZE_W     = SIZE_MSB - SIZE_LSB + 1;
    localparam int CLASS_BIT  = 8;
    localparam int PCODE_LSB  = 4;
    localparam int PCODE_W    = 2;
    localparam int CODE_W     = 3;

    localparam logic [SIZE_W-1:0] SZ_256M = 2'b00;
    localparam logic [SIZE_W-1:0] SZ_1T   = 2'b01;

    typedef enum logic [2:0] {
        OP_WRITE    = 3'd0,
        OP_RD_TAG   = 3'd1,
        OP_RD_SEG   = 3'd2,
        OP_FIND     = 3'd3,
        OP_INV_LOC  = 3'd4,
        OP_INV_GLB  = 3'd5,
        OP_INV_CODE = 3'd6,
        OP_PURGE    = 3'd7
    } slb_op_e;
endpackage

// File: rtl/slb_match.sv
// Fully associative priority match of one segment number against the table.
// Assumes: tags of 1 TB entries are compared with their low twelve bits
// forced to zero in the key, so a 1 TB tag with nonzero low bits never hits.
module slb_match
    import slb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ESID_W-1:0]                 key,
    input  logic [ENTRIES-1:0][ESID_W-1:0]    tag_esid,
    input  logic [ENTRIES-1:0]                tag_vld,
    input  logic [ENTRIES-1:0][SIZE_W-1:0]    tag_size,
    output logic                              hit,
    output logic [IDX_W-1:0]                  idx
);
    logic [ESID_W-1:0]  key_tera;
    logic [ENTRIES-1:0] match;

    // Key aligned to a 1 TB boundary.
    assign key_tera = {key[ESID_W-1:TERA_LOW_W], {TERA_LOW_W{1'b0}}};

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        // Per-entry compare, size field selects the key alignment.
        assign match[i] = tag_vld[i] &&
            (((tag_size[i] == SZ_256M) && (tag_esid[i] == key)) ||
             ((tag_size[i] == SZ_1T)   && (tag_esid[i] == key_tera)));
    end

    // Lowest matching index wins.
    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) idx = i[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/slb_wcheck.sv
// Validity check of an indexed write: slot range, reserved tag bits,
// segment size code, 1 TB enable and base page-size code.
// Assumes: PSZ_MASK bit n set means page-size code n is supported.
module slb_wcheck
    import slb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter logic [(1<<PCODE_W)-1:0] PSZ_MASK = 4'b1011
) (
    input  logic [WORD_W-1:0] tag_op,
    input  logic [WORD_W-1:0] seg_op,
    input  logic              en_1t,
    output logic              slot_ok,
    output logic              reject
);
    localparam logic [SLOT_W-1:0] SLOT_LIMIT = SLOT_W'(ENTRIES);

    logic [SIZE_W-1:0]  size_code;
    logic [PCODE_W-1:0] pcode;
    logic               rsv_bad, size_bad, tera_bad, pcode_bad;

    // Field extraction and individual rejection causes.
    always_comb begin
        size_code = seg_op[SIZE_MSB:SIZE_LSB];
        pcode     = seg_op[PCODE_LSB +: PCODE_W];
        slot_ok   = tag_op[SLOT_W-1:0] < SLOT_LIMIT;
        rsv_bad   = |tag_op[RSV_MSB:RSV_LSB];
        size_bad  = (size_code != SZ_256M) && (size_code != SZ_1T);
        tera_bad  = (size_code == SZ_1T) && !en_1t;
        pcode_bad = !PSZ_MASK[pcode];
        reject    = !slot_ok || rsv_bad || size_bad || tera_bad || pcode_bad;
    end
endmodule

// File: rtl/slb_inval.sv
// Clear mask for the bulk invalidate and purge commands.
// Assumes: the caller ANDs the mask with the command strobe; clearing an
// already invalid entry is harmless.
module slb_inval
    import slb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic              do_code,
    input  logic              do_purge,
    input  logic [CODE_W-1:0] code,
    input  logic [ENTRIES-1:0] cls,
    output logic [ENTRIES-1:0] clr
);
    logic none, with_zero, by_class;

    // Decode of the variant code; undefined code 5 behaves like code 0.
    always_comb begin
        none      = (code == 3'd7);
        with_zero = (code == 3'd3) || (code == 3'd4);
        by_class  = (code == 3'd3);
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_clr
        // Per-entry clear decision.
        assign clr[i] = do_purge ||
            (do_code && !none && ((i != 0) || with_zero) && !(by_class && !cls[i]));
    end
endmodule

// File: rtl/slb_array.sv
// Segment lookaside table: registered entries, a combinational lookup port
// and a one-command-per-cycle maintenance port with a registered response.
// Assumes: commands are accepted every cycle; the response and any flush
// pulse appear the cycle after the command.
module slb_array
    import slb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter logic [(1<<PCODE_W)-1:0] PSZ_MASK = 4'b1011,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [WORD_W-1:0] cmd_a,
    input  logic [WORD_W-1:0] cmd_b,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic              mode64,
    input  logic              en_1t,
    input  logic [ESID_W-1:0] lk_seg_addr,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [WORD_W-1:0] lk_seg,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [WORD_W-1:0] rsp_data,
    output logic              flush_local,
    output logic              flush_global
);
    logic [ENTRIES-1:0][ESID_W-1:0] esid_q;
    logic [ENTRIES-1:0]             vld_q;
    logic [ENTRIES-1:0][WORD_W-1:0] seg_q;
    logic [ENTRIES-1:0][SIZE_W-1:0] size_w;
    logic [ENTRIES-1:0]             cls_w;

    slb_op_e           op;
    logic [IDX_W-1:0]  slot_idx;
    logic              slot_ok, wr_reject;
    logic [ESID_W-1:0] cmd_key;
    logic              c_hit;
    logic [IDX_W-1:0]  c_idx;
    logic [ENTRIES-1:0] clr_mask;

    assign op       = slb_op_e'(cmd_op);
    assign slot_idx = cmd_a[IDX_W-1:0];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_fields
        // Size and class fields seen by the match and invalidate logic.
        assign size_w[i] = seg_q[i][SIZE_MSB:SIZE_LSB];
        assign cls_w[i]  = seg_q[i][CLASS_BIT];
    end

    // Command search key, truncated to 32 address bits for find outside 64-bit mode.
    always_comb begin
        if (op == OP_FIND && !mode64)
            cmd_key = {{(ESID_W - (32 - ESID_LSB)){1'b0}}, cmd_a[31:ESID_LSB]};
        else
            cmd_key = cmd_a[WORD_W-1:ESID_LSB];
    end

    slb_match #(.ENTRIES(ENTRIES)) u_lk_match (
        .key      (lk_seg_addr),
        .tag_esid (esid_q),
        .tag_vld  (vld_q),
        .tag_size (size_w),
        .hit      (lk_hit),
        .idx      (lk_idx)
    );

    slb_match #(.ENTRIES(ENTRIES)) u_cmd_match (
        .key      (cmd_key),
        .tag_esid (esid_q),
        .tag_vld  (vld_q),
        .tag_size (size_w),
        .hit      (c_hit),
        .idx      (c_idx)
    );

    slb_wcheck #(.ENTRIES(ENTRIES), .PSZ_MASK(PSZ_MASK)) u_wcheck (
        .tag_op  (cmd_a),
        .seg_op  (cmd_b),
        .en_1t   (en_1t),
        .slot_ok (slot_ok),
        .reject  (wr_reject)
    );

    slb_inval #(.ENTRIES(ENTRIES)) u_inval (
        .do_code  (op == OP_INV_CODE),
        .do_purge (op == OP_PURGE),
        .code     (cmd_code),
        .cls      (cls_w),
        .clr      (clr_mask)
    );

    // Segment word of the lookup port; zero on a miss.
    assign lk_seg = lk_hit ? seg_q[lk_idx] : '0;

    // Table state, response and flush registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            esid_q       <= '0;
            vld_q        <= '0;
            seg_q        <= '0;
            rsp_valid    <= 1'b0;
            rsp_err      <= 1'b0;
            rsp_data     <= '0;
            flush_local  <= 1'b0;
            flush_global <= 1'b0;
        end else begin
            rsp_valid    <= cmd_valid;
            rsp_err      <= 1'b0;
            rsp_data     <= '0;
            flush_local  <= 1'b0;
            flush_global <= 1'b0;
            if (cmd_valid) begin
                case (op)
                    OP_WRITE: begin
                        rsp_err <= wr_reject;
                        if (!wr_reject) begin
                            esid_q[slot_idx] <= cmd_a[WORD_W-1:ESID_LSB];
                            vld_q[slot_idx]  <= cmd_a[VALID_BIT];
                            seg_q[slot_idx]  <= cmd_b;
                        end
                    end
                    OP_RD_TAG: begin
                        rsp_err <= !slot_ok;
                        if (slot_ok)
                            rsp_data <= {esid_q[slot_idx], vld_q[slot_idx], {VALID_BIT{1'b0}}};
                    end
                    OP_RD_SEG: begin
                        rsp_err <= !slot_ok;
                        if (slot_ok) rsp_data <= seg_q[slot_idx];
                    end
                    OP_FIND: begin
                        rsp_data <= c_hit ? seg_q[c_idx] : '1;
                    end
                    OP_INV_LOC, OP_INV_GLB: begin
                        if (c_hit) begin
                            vld_q[c_idx] <= 1'b0;
                            flush_local  <= (op == OP_INV_LOC);
                            flush_global <= (op == OP_INV_GLB);
                        end
                    end
                    OP_INV_CODE, OP_PURGE: begin
                        vld_q       <= vld_q & ~clr_mask;
                        flush_local <= 1'b1;
                    end
                    default: begin
                        rsp_err <= 1'b1;
                    end
                endcase
            end
        end
    end

    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);                                          // R12
    AST_FLUSH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush_local && flush_global));                                   // R8
    AST_LOOKUP_HITS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> vld_q[lk_idx]);                                         // R4
    AST_REJECT_KEEPS_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_WRITE && wr_reject) |=> ($stable(vld_q) && $stable(seg_q) && $stable(esid_q))); // R3
    AST_CODE7_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_INV_CODE && cmd_code == 3'd7) |=> $stable(vld_q)); // R9
    AST_ENTRY0_SPARED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && op == OP_INV_CODE && cmd_code != 3'd3 && cmd_code != 3'd4)
        |=> (vld_q[0] == $past(vld_q[0])));                                // R9
    AST_BULK_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (op == OP_INV_CODE || op == OP_PURGE)) |=> (flush_local && !flush_global)); // R11
endmodule

// File: tb/slb_array_test.sv
`timescale 1ns/1ps
module slb_array_test;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [63:0] cmd_a = '0;
    logic [63:0] cmd_b = '0;
    logic [2:0]  cmd_code = '0;
    logic        mode64 = 1'b1;
    logic        en_1t = 1'b1;
    logic [35:0] lk_seg_addr = '0;
    logic        lk_hit;
    logic [2:0]  lk_idx;
    logic [63:0] lk_seg;
    logic        rsp_valid, rsp_err, flush_local, flush_global;
    logic [63:0] rsp_data;

    int total = 0;
    int bad = 0;

    // Reference model of the table.
    logic [35:0] m_esid [N];
    logic        m_vld  [N];
    logic [63:0] m_seg  [N];

    // Last response captured after a command.
    logic        r_valid, r_err, r_fl, r_fg;
    logic [63:0] r_data;

    slb_array uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_a(cmd_a), .cmd_b(cmd_b), .cmd_code(cmd_code), .mode64(mode64),
        .en_1t(en_1t), .lk_seg_addr(lk_seg_addr), .lk_hit(lk_hit),
        .lk_idx(lk_idx), .lk_seg(lk_seg), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_data(rsp_data), .flush_local(flush_local),
        .flush_global(flush_global)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_tag(input logic [35:0] esid, input logic v, input logic [11:0] slot);
        return {esid, v, 15'b0, slot};
    endfunction

    function automatic logic [63:0] mk_seg(input logic [1:0] sz, input logic cls, input logic [1:0] pc, input logic [52:0] pay);
        return {sz, pay, cls, 2'b00, pc, 4'h0};
    endfunction

    function automatic logic [35:0] e_esid(input int i);
        if (i % 2 == 0) return {24'hABC000 + 24'(i), 12'h010 + 12'(i)};
        return {24'h5A0000 + 24'(i), 12'h000};
    endfunction

    function automatic logic [63:0] e_seg(input int i);
        logic [1:0] pc;
        pc = (i % 3 == 0) ? 2'd0 : (i % 3 == 1) ? 2'd1 : 2'd3;
        return mk_seg((i % 2 == 1) ? 2'b01 : 2'b00, i[1], pc, 53'(i * 1001 + 7));
    endfunction

    // Model priority lookup; returns -1 on a miss.
    function automatic int m_lookup(input logic [35:0] key);
        for (int i = 0; i < N; i++) begin
            if (m_vld[i]) begin
                if (m_seg[i][63:62] == 2'b00 && m_esid[i] == key) return i;
                if (m_seg[i][63:62] == 2'b01 && m_esid[i] == {key[35:12], 12'h000}) return i;
            end
        end
        return -1;
    endfunction

    task automatic do_cmd(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b, input logic [2:0] code);
        @(negedge clk);
        cmd_op = op; cmd_a = a; cmd_b = b; cmd_code = code; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        r_valid = rsp_valid; r_err = rsp_err; r_data = rsp_data;
        r_fl = flush_local; r_fg = flush_global;
    endtask

    task automatic wr_ok(input int slot, input logic [35:0] esid, input logic [63:0] seg);
        do_cmd(3'd0, mk_tag(esid, 1'b1, 12'(slot)), seg, 3'd0);
        chk(r_valid && !r_err, "R2 write accepted", {r_valid, r_err}, 2'b10);
        m_esid[slot] = esid; m_vld[slot] = 1'b1; m_seg[slot] = seg;
    endtask

    task automatic fill_all();
        for (int i = 0; i < N; i++) wr_ok(i, e_esid(i), e_seg(i));
    endtask

    task automatic lk_check(input logic [35:0] key, input string req);
        int e;
        @(negedge clk);
        lk_seg_addr = key;
        #1;
        e = m_lookup(key);
        if (e < 0) chk(!lk_hit, req, {63'b0, lk_hit}, 64'd0);
        else chk(lk_hit && lk_idx == 3'(e) && lk_seg == m_seg[e], req, {lk_hit, lk_idx, lk_seg[59:0]}, {1'b1, 3'(e), m_seg[e][59:0]});
    endtask

    task automatic rd_tag_check(input int slot, input string req);
        do_cmd(3'd1, {52'b0, 12'(slot)}, 64'b0, 3'd0);
        chk(!r_err && r_data == {m_esid[slot], m_vld[slot], 27'b0}, req, r_data, {m_esid[slot], m_vld[slot], 27'b0});
    endtask

    task automatic rd_seg_check(input int slot, input string req);
        do_cmd(3'd2, {52'b0, 12'(slot)}, 64'b0, 3'd0);
        chk(!r_err && r_data == m_seg[slot], req, r_data, m_seg[slot]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [35:0] k;
        for (int i = 0; i < N; i++) begin m_esid[i] = '0; m_vld[i] = 1'b0; m_seg[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(!rsp_valid && !flush_local && !flush_global, "R1 outputs idle", {rsp_valid, flush_local, flush_global}, 0);
        lk_check(e_esid(0), "R1 lookup misses");
        for (int i = 0; i < N; i++) rd_tag_check(i, "R1 tag cleared");

        // R2/R12: fill and read back
        fill_all();
        chk(r_valid, "R12 response follows command", r_valid, 1);
        for (int i = 0; i < N; i++) begin
            rd_tag_check(i, "R2 tag readback");
            rd_seg_check(i, "R2 segment readback");
        end
        @(negedge clk);
        chk(!rsp_valid, "R12 response lasts one cycle", rsp_valid, 0);
        do_cmd(3'd1, 64'd8, 64'b0, 3'd0);
        chk(r_err && r_data == 0, "R2 read out of range", {r_err, r_data[62:0]}, {1'b1, 63'b0});
        do_cmd(3'd2, 64'hFFF, 64'b0, 3'd0);
        chk(r_err && r_data == 0, "R2 read slot 4095", {r_err, r_data[62:0]}, {1'b1, 63'b0});

        // R4/R5: lookup sweep around every stored number
        for (int i = 0; i < N; i++) begin
            lk_check(e_esid(i), "R4 R5 exact key");
            lk_check(e_esid(i) ^ 36'h1, "R4 R5 bit0 flip");
            lk_check(e_esid(i) ^ 36'h800, "R5 bit11 flip");
            lk_check(e_esid(i) ^ 36'h1000, "R5 bit12 flip");
        end

        // R3: rejected writes leave slot 1 unchanged
        do_cmd(3'd0, mk_tag(36'h1, 1'b1, 12'd8), mk_seg(2'b00, 1'b0, 2'd0, 53'd1), 3'd0);
        chk(r_err, "R3 slot out of range", r_err, 1);
        do_cmd(3'd0, mk_tag(36'h1, 1'b1, 12'd1) | 64'h0000_0000_0100_0000, mk_seg(2'b00, 1'b0, 2'd0, 53'd1), 3'd0);
        chk(r_err, "R3 reserved bit", r_err, 1);
        do_cmd(3'd0, mk_tag(36'h1, 1'b1, 12'd1), mk_seg(2'b10, 1'b0, 2'd0, 53'd1), 3'd0);
        chk(r_err, "R3 size code 2", r_err, 1);
        do_cmd(3'd0, mk_tag(36'h1, 1'b1, 12'd1), mk_seg(2'b11, 1'b0, 2'd0, 53'd1), 3'd0);
        chk(r_err, "R3 size code 3", r_err, 1);
        do_cmd(3'd0, mk_tag(36'h1, 1'b1, 12'd1), mk_seg(2'b00, 1'b0, 2'd2, 53'd1), 3'd0);
        chk(r_err, "R3 page code 2", r_err, 1);
        en_1t = 1'b0;
        do_cmd(3'd0, mk_tag(36'h1000, 1'b1, 12'd1), mk_seg(2'b01, 1'b0, 2'd0, 53'd1), 3'd0);
        chk(r_err, "R3 1TB disabled", r_err, 1);
        en_1t = 1'b1;
        rd_tag_check(1, "R3 tag unchanged");
        rd_seg_check(1, "R3 segment unchanged");

        // R6: duplicate number, lowest index wins
        wr_ok(5, e_esid(2), mk_seg(2'b00, 1'b1, 2'd3, 53'h55));
        lk_check(e_esid(2), "R6 lowest index");
        // R8: local then global invalidate on the duplicate pair
        do_cmd(3'd4, {e_esid(2), 28'h123}, 64'b0, 3'd0);
        m_vld[2] = 1'b0;
        chk(r_fl && !r_fg, "R8 local flush", {r_fl, r_fg}, 2'b10);
        rd_tag_check(2, "R8 local cleared");
        lk_check(e_esid(2), "R6 R8 next match");
        do_cmd(3'd5, {e_esid(2), 28'h0}, 64'b0, 3'd0);
        m_vld[5] = 1'b0;
        chk(!r_fl && r_fg, "R8 global flush", {r_fl, r_fg}, 2'b01);
        rd_tag_check(5, "R8 global cleared");
        do_cmd(3'd4, {e_esid(2), 28'h0}, 64'b0, 3'd0);
        chk(r_valid && !r_fl && !r_fg, "R8 miss no flush", {r_valid, r_fl, r_fg}, 3'b100);
        for (int i = 0; i < N; i++) rd_tag_check(i, "R8 miss no change");

        // R7: find, with and without truncation
        k = {32'h0, 4'h5};
        wr_ok(3, k, mk_seg(2'b00, 1'b0, 2'd1, 53'h3A3A));
        mode64 = 1'b0;
        do_cmd(3'd3, 64'hDEAD_BEEF_5123_4567, 64'b0, 3'd0);
        chk(!r_err && r_data == m_seg[3], "R7 truncated hit", r_data, m_seg[3]);
        mode64 = 1'b1;
        do_cmd(3'd3, 64'hDEAD_BEEF_5123_4567, 64'b0, 3'd0);
        chk(!r_err && r_data == '1, "R7 full address miss", r_data, '1);
        do_cmd(3'd3, {e_esid(7) | 36'h0AB, 28'h0}, 64'b0, 3'd0);
        chk(r_data == m_seg[7], "R7 find 1TB hit", r_data, m_seg[7]);

        // R9/R10/R11: every bulk code on a full table
        for (int c = 0; c < 8; c++) begin
            fill_all();
            do_cmd(3'd6, 64'b0, 64'b0, 3'(c));
            chk(r_fl && !r_fg, "R11 bulk flush", {r_fl, r_fg}, 2'b10);
            for (int i = 0; i < N; i++) begin
                bit clr;
                clr = (c != 7) && ((i != 0) || c == 3 || c == 4) && !(c == 3 && m_seg[i][8] == 1'b0);
                if (clr) m_vld[i] = 1'b0;
                rd_tag_check(i, (c == 3) ? "R10 class rule" : "R9 bulk code");
            end
        end
        fill_all();
        do_cmd(3'd7, 64'b0, 64'b0, 3'd0);
        chk(r_fl && !r_fg, "R11 purge flush", {r_fl, r_fg}, 2'b10);
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 1'b0;
            rd_tag_check(i, "R11 purge clears all");
        end
        lk_check(e_esid(0), "R11 purge lookup miss");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule